// File: doc/BRIEF.md
# Misaligned Access Splitter and Checker

This block sits between a load/store unit and a 64-bit data bus. It accepts one memory request at a time: a byte address, a size of 1, 2, 4 or 8 bytes, an access class and a write flag. In the cycle the request is presented, it decides from the class, the boundaries the access straddles and three mode inputs whether the access must raise an alignment interrupt. These mode inputs are little-endian mode, the segment T flag and data relocation.

A request that does not trap is performed as one or two transfers on a valid/ready bus. Each transfer carries an 8-byte-aligned address and a per-lane byte enable. Read bytes from the two halves of a split access are merged and returned right-justified in a single response pulse. A trapping request issues no transfer and leaves its address in a fault register.

Top module: `misalign_split`

## Requirements
- R1: With `le_mode` = 1, any access that is not naturally aligned traps, and any class-4 (load/store multiple or string) access traps even when aligned. An aligned integer access in that mode does not trap.
- R2: An integer (class 0) halfword whose bytes stay inside one aligned 4-byte word completes in exactly one bus transfer.
- R3: An integer halfword or word (size code 1 or 2) that crosses a 4-byte or 8-byte boundary takes exactly two transfers. The first transfer covers the bytes up to the next 4-byte boundary and the second covers the rest. Enable bit i of `bus_be` selects the byte at `bus_addr` + i, and every transfer enables at least one byte.
- R4: An access crossing a 4 KB boundary traps when `seg_t` = 0 and `data_reloc` = 1. Otherwise an integer access that crosses it is done as two transfers.
- R5: An access whose first and last bytes lie in different 256 MB segments always traps.
- R6: An atomic class (class 1) access whose address is not a multiple of 4 traps.
- R7: A single-precision float access (class 2) that is not naturally aligned traps. An aligned one takes one transfer.
- R8: A double-precision float access (class 3, size code 3) traps if its address is not a multiple of 4. On an odd word it takes two transfers split at the 8-byte boundary, and when 8-byte aligned it takes one.
- R9: A load/store multiple access (class 4) whose address is not a multiple of 4 traps.
- R10: `trap` is driven in the same cycle as the request. A trapping request issues no bus transfer, and from the next cycle `fault_addr` holds the request address.
- R11: For a read, `rsp_valid` pulses for one cycle, one clock edge after the last transfer handshake. `rsp_data` bits [8k+7:8k] hold the byte at address + k, and bytes beyond the size are zero.
- R12: For a write, each enabled lane carries byte k of the right-justified `req_wdata`, where k is the lane's address minus the request address. Address, enables and data are held stable while `bus_valid` is high and `bus_ready` is low.
- R13: After reset, `req_ready` = 1, `bus_valid` = 0, `rsp_valid` = 0 and `fault_addr` = 0.

Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. Class codes are 0 integer, 1 atomic reserve/conditional, 2 single float, 3 double float and 4 load/store multiple or string.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | AW | Byte address of the access |
| req_size | input | 2 | Size code (1, 2, 4, 8 bytes) |
| req_class | input | 3 | Access class code |
| req_write | input | 1 | 1 for a store |
| req_wdata | input | 64 | Store data, right-justified |
| le_mode | input | 1 | Little-endian mode |
| seg_t | input | 1 | Segment T flag |
| data_reloc | input | 1 | Data relocation enabled |
| trap | output | 1 | Alignment interrupt for the current request |
| fault_addr | output | AW | Address of the last trapping request |
| bus_valid | output | 1 | Bus transfer requested |
| bus_ready | input | 1 | Bus accepts the transfer this cycle |
| bus_addr | output | AW | 8-byte-aligned transfer address |
| bus_be | output | 8 | Byte-lane enables |
| bus_write | output | 1 | Transfer direction |
| bus_wdata | output | 64 | Lane-placed store data |
| bus_rdata | input | 64 | Lane-placed read data, valid at the handshake |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 64 | Merged read data, right-justified |

## Verification
`trap` is combinational, so the bench raises a request after a falling edge and reads `trap` one time unit later, in the same cycle. `fault_addr` and the absence of bus activity are read at the following falling edge. With `bus_ready` held high, a non-trapping request produces its `rsp_valid` exactly N rising edges after acceptance, where N is the number of transfers. When `bus_ready` is withheld, the wait grows by one edge per stall cycle. The bench counts falling edges from acceptance to the pulse and compares that count with the expected transfer count plus any stalls. A falling-edge monitor tallies handshakes and enabled bytes and checks each store lane against the right-justified data.

// File: rtl/misalign_split.sv
module misalign_split #(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12,
  parameter int SEG_BITS  = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic [2:0]    req_class,
  input  logic          req_write,
  input  logic [63:0]   req_wdata,
  input  logic          le_mode,
  input  logic          seg_t,
  input  logic          data_reloc,
  output logic          trap,
  output logic [AW-1:0] fault_addr,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_be,
  output logic          bus_write,
  output logic [63:0]   bus_wdata,
  input  logic [63:0]   bus_rdata,
  output logic          rsp_valid,
  output logic [63:0]   rsp_data
);

  localparam logic [2:0] C_INT  = 3'd0;
  localparam logic [2:0] C_ATOM = 3'd1;
  localparam logic [2:0] C_SGL  = 3'd2;
  localparam logic [2:0] C_DBL  = 3'd3;
  localparam logic [2:0] C_MULT = 3'd4;

  typedef enum logic [1:0] {IDLE, XF1, XF2} st_t;
  st_t st;

  logic [3:0]    nb, c1;
  logic [AW-1:0] last;
  logic          unused_lo;
  logic          misal, wmis, x4k, x256, bad, gran8, split, take;

  assign nb        = 4'd1 << req_size;
  assign last      = req_addr + AW'(nb - 4'd1);
  assign unused_lo = ^last[1:0];
  assign misal     = (req_addr[2:0] & 3'(nb - 4'd1)) != 3'd0;
  assign wmis      = req_addr[1:0] != 2'd0;
  assign x4k       = req_addr[AW-1:PAGE_BITS] != last[AW-1:PAGE_BITS];
  assign x256      = req_addr[AW-1:SEG_BITS] != last[AW-1:SEG_BITS];

  assign bad = x256
             | (le_mode & (misal | (req_class == C_MULT)))
             | (wmis & ((req_class == C_ATOM) | (req_class == C_DBL) | (req_class == C_MULT)))
             | (misal & (req_class == C_SGL))
             | (x4k & ~seg_t & data_reloc);

  assign gran8 = req_size == 2'd3;
  assign split = gran8 ? (req_addr[2:0] != 3'd0) : (req_addr[AW-1:2] != last[AW-1:2]);
  assign c1    = !split ? nb
               : gran8  ? 4'd8 - {1'b0, req_addr[2:0]}
               :          4'd4 - {2'b0, req_addr[1:0]};

  assign req_ready = st == IDLE;
  assign trap      = req_valid & req_ready & bad;
  assign take      = req_valid & req_ready & ~bad;

  logic [AW-1:0] a_q;
  logic [3:0]    n_q, c1_q;
  logic          two_q, wr_q;
  logic [63:0]   wd_q, part_q;

  logic [AW-1:0] cs;
  logic [3:0]    cn;
  logic [63:0]   cd, keep, got;
  logic [8:0]    m9;

  assign cs = (st == XF2) ? a_q + AW'(c1_q) : a_q;
  assign cn = (st == XF2) ? n_q - c1_q : c1_q;
  assign cd = (st == XF2) ? wd_q >> {c1_q, 3'b0} : wd_q;
  assign m9 = (9'd1 << cn) - 9'd1;

  always_comb
    for (int i = 0; i < 8; i++) keep[8*i +: 8] = {8{m9[i]}};

  assign got       = (bus_rdata >> {cs[2:0], 3'b0}) & keep;
  assign bus_valid = st != IDLE;
  assign bus_addr  = {cs[AW-1:3], 3'b000};
  assign bus_be    = m9[7:0] << cs[2:0];
  assign bus_write = wr_q;
  assign bus_wdata = cd << {cs[2:0], 3'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= IDLE;
      fault_addr <= '0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      a_q        <= '0;
      n_q        <= '0;
      c1_q       <= '0;
      two_q      <= 1'b0;
      wr_q       <= 1'b0;
      wd_q       <= '0;
      part_q     <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (trap) fault_addr <= req_addr;
      case (st)
        IDLE: if (take) begin
          a_q   <= req_addr;
          n_q   <= nb;
          c1_q  <= c1;
          two_q <= split;
          wr_q  <= req_write;
          wd_q  <= req_wdata;
          st    <= XF1;
        end
        XF1: if (bus_ready) begin
          if (two_q) begin
            part_q <= got;
            st     <= XF2;
          end else begin
            rsp_valid <= 1'b1;
            rsp_data  <= wr_q ? '0 : got;
            st        <= IDLE;
          end
        end
        XF2: if (bus_ready) begin
          rsp_valid <= 1'b1;
          rsp_data  <= wr_q ? '0 : (part_q | (got << {c1_q, 3'b0}));
          st        <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

endmodule

module misalign_split_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_addr,
  input logic [1:0]  req_size,
  input logic [2:0]  req_class,
  input logic        trap,
  input logic [31:0] fault_addr,
  input logic        bus_valid,
  input logic        bus_ready,
  input logic [31:0] bus_addr,
  input logic [7:0]  bus_be,
  input logic [63:0] bus_wdata,
  input logic        rsp_valid
);

  // R10
  trap_nobus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> !bus_valid);

  // R10
  trap_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> fault_addr == $past(req_addr));

  // R5
  seg_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_size == 2'd1 && req_addr[27:0] == 28'hFFFFFFF) |-> trap);

  // R6
  atom_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_class == 3'd1 && req_addr[1:0] != 2'd0) |-> trap);

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_be) && $stable(bus_wdata)));

  // R11
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R3
  be_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_be != 8'd0);

endmodule

bind misalign_split misalign_split_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_size(req_size), .req_class(req_class), .trap(trap),
  .fault_addr(fault_addr), .bus_valid(bus_valid), .bus_ready(bus_ready),
  .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid)
);

// File: tb/tb_misalign_split.sv
module tb_misalign_split;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 26;
  localparam logic [63:0] WD = 64'h8877665544332211;

  // {addr, size, class, le, t, dr, write, trap, transfers, requirement}
  localparam logic [47:0] VEC [NV] = '{
    {32'h00001000, 2'd1, 3'd0, 3'b000, 1'b0, 1'b0, 2'd1, 4'd2},  // R2
    {32'h00001001, 2'd1, 3'd0, 3'b000, 1'b0, 1'b0, 2'd1, 4'd2},  // R2
    {32'h00001003, 2'd1, 3'd0, 3'b000, 1'b0, 1'b0, 2'd2, 4'd3},  // R3
    {32'h00001007, 2'd1, 3'd0, 3'b000, 1'b0, 1'b0, 2'd2, 4'd3},  // R3
    {32'h00001002, 2'd2, 3'd0, 3'b000, 1'b0, 1'b0, 2'd2, 4'd3},  // R3
    {32'h00001006, 2'd2, 3'd0, 3'b000, 1'b1, 1'b0, 2'd2, 4'd12}, // R12
    {32'h00001FFE, 2'd2, 3'd0, 3'b001, 1'b0, 1'b1, 2'd0, 4'd4},  // R4
    {32'h00001FFE, 2'd2, 3'd0, 3'b011, 1'b0, 1'b0, 2'd2, 4'd4},  // R4
    {32'h00001FFF, 2'd1, 3'd0, 3'b000, 1'b0, 1'b0, 2'd2, 4'd4},  // R4
    {32'h0FFFFFFE, 2'd2, 3'd0, 3'b010, 1'b0, 1'b1, 2'd0, 4'd5},  // R5
    {32'h0FFFFFFF, 2'd1, 3'd0, 3'b000, 1'b0, 1'b1, 2'd0, 4'd5},  // R5
    {32'h00001001, 2'd1, 3'd0, 3'b100, 1'b0, 1'b1, 2'd0, 4'd1},  // R1
    {32'h00001000, 2'd2, 3'd4, 3'b100, 1'b0, 1'b1, 2'd0, 4'd1},  // R1
    {32'h00001002, 2'd1, 3'd0, 3'b100, 1'b0, 1'b0, 2'd1, 4'd1},  // R1
    {32'h00001000, 2'd3, 3'd0, 3'b100, 1'b0, 1'b0, 2'd1, 4'd1},  // R1
    {32'h00001002, 2'd2, 3'd1, 3'b000, 1'b0, 1'b1, 2'd0, 4'd6},  // R6
    {32'h00001004, 2'd2, 3'd1, 3'b000, 1'b0, 1'b0, 2'd1, 4'd6},  // R6
    {32'h00001002, 2'd2, 3'd2, 3'b000, 1'b0, 1'b1, 2'd0, 4'd7},  // R7
    {32'h00001004, 2'd2, 3'd2, 3'b000, 1'b0, 1'b0, 2'd1, 4'd7},  // R7
    {32'h00001004, 2'd3, 3'd3, 3'b000, 1'b0, 1'b0, 2'd2, 4'd8},  // R8
    {32'h00001002, 2'd3, 3'd3, 3'b000, 1'b0, 1'b1, 2'd0, 4'd8},  // R8
    {32'h00001008, 2'd3, 3'd3, 3'b000, 1'b0, 1'b0, 2'd1, 4'd8},  // R8
    {32'h00001002, 2'd2, 3'd4, 3'b000, 1'b0, 1'b1, 2'd0, 4'd9},  // R9
    {32'h00001004, 2'd2, 3'd4, 3'b000, 1'b0, 1'b0, 2'd1, 4'd9},  // R9
    {32'h00001005, 2'd3, 3'd0, 3'b000, 1'b1, 1'b0, 2'd2, 4'd12}, // R12
    {32'h00001FFC, 2'd3, 3'd3, 3'b001, 1'b0, 1'b1, 2'd0, 4'd4}   // R4
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [2:0]  req_class = '0;
  logic        req_write = 1'b0;
  logic [63:0] req_wdata = '0;
  logic        le_mode = 1'b0, seg_t = 1'b0, data_reloc = 1'b0;
  logic        bus_ready = 1'b1;
  logic        req_ready, trap, bus_valid, bus_write, rsp_valid;
  logic [31:0] fault_addr, bus_addr;
  logic [7:0]  bus_be;
  logic [63:0] bus_wdata, bus_rdata, rsp_data;

  int total = 0, bad = 0;
  int xcnt = 0, bcnt = 0, lane_err = 0, stall_left = 0;
  logic [31:0] cur_addr = '0;
  int          cur_n = 1;
  logic [7:0]  be_log [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  misalign_split dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_class(req_class),
    .req_write(req_write), .req_wdata(req_wdata), .le_mode(le_mode),
    .seg_t(seg_t), .data_reloc(data_reloc), .trap(trap), .fault_addr(fault_addr),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_write(bus_write), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  function automatic logic [7:0] mb(logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  always_comb
    for (int i = 0; i < 8; i++) bus_rdata[8*i +: 8] = mb(bus_addr + 32'(i));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bus_ready = (stall_left == 0);
    if (bus_valid && stall_left > 0) stall_left--;
    if (bus_valid && bus_ready) begin
      if (xcnt < 2) be_log[xcnt] = bus_be;
      xcnt++;
      for (int i = 0; i < 8; i++) if (bus_be[i]) begin
        logic [31:0] k;
        k = bus_addr + 32'(i) - cur_addr;
        bcnt++;
        if (k >= 32'(cur_n)) lane_err++;
        else if (bus_write && bus_wdata[8*i +: 8] != WD[8*k[2:0] +: 8]) lane_err++;
      end
    end
  end

  task automatic run_op(input logic [47:0] v, input int stalls, output int cyc);
    logic [63:0] exp;
    string tag;
    tag = $sformatf("R%0d @%h", v[3:0], v[47:16]);
    @(negedge clk);
    xcnt = 0; bcnt = 0; lane_err = 0; stall_left = stalls;
    be_log[0] = '0; be_log[1] = '0;
    cur_addr = v[47:16]; cur_n = 1 << v[15:14];
    req_addr = v[47:16]; req_size = v[15:14]; req_class = v[13:11];
    le_mode = v[10]; seg_t = v[9]; data_reloc = v[8]; req_write = v[7];
    req_wdata = WD; req_valid = 1'b1;
    #1;
    chk(trap == v[6], {tag, " trap"}, 64'(trap), 64'(v[6]));
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    if (v[6]) begin
      chk(!bus_valid && fault_addr == cur_addr, {tag, " R10 fault"}, 64'(fault_addr), 64'(cur_addr));
      @(negedge clk);
      chk(xcnt == 0, {tag, " R10 no transfer"}, 64'(xcnt), 64'd0);
    end else begin
      while (!rsp_valid && cyc < 40) begin
        @(negedge clk);
        cyc++;
      end
      chk(cyc == v[5:4] + stalls, {tag, " response cycle"}, 64'(cyc), 64'(v[5:4] + stalls));
      chk(xcnt == v[5:4] && bcnt == cur_n, {tag, " transfers/bytes"}, 64'(xcnt), 64'(v[5:4]));
      chk(lane_err == 0, {tag, " R12 lanes"}, 64'(lane_err), 64'd0);
      if (!v[7]) begin
        exp = '0;
        for (int k = 0; k < cur_n; k++) exp[8*k +: 8] = mb(cur_addr + 32'(k));
        chk(rsp_data == exp, {tag, " R11 data"}, rsp_data, exp);
      end
    end
  endtask

  initial begin
    int cyc;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    // R13
    chk(req_ready && !bus_valid && !rsp_valid && fault_addr == 0, "R13 reset",
        {bus_valid, rsp_valid, req_ready}, 64'd1);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) run_op(VEC[i], 0, cyc);
    // R3 lane layout of a halfword split at a 4-byte boundary
    run_op({32'h00001003, 2'd1, 3'd0, 3'b000, 1'b0, 1'b0, 2'd2, 4'd3}, 0, cyc);
    chk(be_log[0] == 8'h08 && be_log[1] == 8'h10, "R3 enables", {be_log[0], be_log[1]}, 64'h0810);
    // R8 odd-word double split at the 8-byte boundary
    run_op({32'h00001004, 2'd3, 3'd3, 3'b000, 1'b0, 1'b0, 2'd2, 4'd8}, 0, cyc);
    chk(be_log[0] == 8'hF0 && be_log[1] == 8'h0F, "R8 enables", {be_log[0], be_log[1]}, 64'hF00F);
    // R12 stalled bus holds the transfer
    run_op({32'h00001006, 2'd2, 3'd0, 3'b000, 1'b0, 1'b0, 2'd2, 4'd12}, 3, cyc);
    // R11 single pulse
    @(negedge clk);
    chk(!rsp_valid, "R11 pulse width", 64'(rsp_valid), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule